// File: doc/BRIEF.md
# Three-Slot In-Order Decode Steering

This block sits between an instruction queue and the micro-op path. Each cycle it looks at the three oldest instructions in the queue. These have already been classified: each one has a valid bit, a micro-op count, a memory-access flag and up to four micro-op payloads. The block then decides how many of them can be decoded together, in program order.

The head instruction goes to a general slot. That slot takes any instruction and expands it into as many as four micro-ops. The two younger instructions go to restricted slots. A restricted slot emits one micro-op, and it only takes instructions that need exactly one micro-op and do not touch memory. The first younger instruction that fails this test stops itself and everything behind it for that cycle. It is retried once it reaches the head.

A head instruction that needs more than four micro-ops is handed to a micro-op sequencer. Slot decode then stops until the sequencer reports completion. The accepted micro-ops go out on a packed six-lane bundle with one valid bit per lane. The consume count goes back to the queue in the same register stage as the bundle. The queue is expected to advance its window by the consume count in the cycle that count appears.

Top module: `decode_steer`

## Requirements
- R1: While reset is asserted and right after it is released, the consume count is 0, every lane valid bit is 0 and the sequencer start output is 0.
- R2: A valid head instruction with a micro-op count of 1 to 4 is accepted whether or not it accesses memory. Its micro-ops appear in lanes 0 to count-1, in payload order, one cycle after the decision.
- R3: A younger instruction is accepted into a restricted slot only if it is valid, its count is exactly 1, its memory flag is 0, and every older instruction in the window was accepted. Each accepted restricted instruction fills the lane right after the micro-ops of the older accepted instructions.
- R4: The first younger instruction that is not accepted blocks every later instruction in the window for that cycle, even if a later one is eligible on its own.
- R5: An instruction with its memory flag set is never accepted by a restricted slot, even when its count is 1.
- R6: A valid head instruction whose count exceeds 4 raises the sequencer start output for exactly one cycle. In that cycle the consume count is 1, no lane is valid, and no younger instruction is accepted.
- R7: From the start pulse until the cycle in which the sequencer-done input is sampled high, nothing is consumed and no lane is valid. Slot decode resumes on the decision made in the cycle after done.
- R8: While the downstream-ready input is low, the next consume count is 0 and the lane payloads and valid bits keep their values.
- R9: The flush input forces the consume count to 0 in the same cycle. It also cancels a pending sequencer handoff, so decode resumes in the cycle after flush without a done.
- R10: The consume count equals the number of instructions accepted (0 to 3), and the valid lanes always form a contiguous run that starts at lane 0.
- R11: An invalid head consumes nothing and emits nothing. An invalid younger entry blocks itself and every later entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Cancel the sequencer handoff and zero the consume count |
| downReady | input | 1 | Downstream can accept a new bundle |
| seqDone | input | 1 | Sequencer finished the long instruction |
| instValid | input | 3 | Valid bit per window entry (bit 0 = head) |
| instUopCnt | input | 3x4 | Micro-op count per entry |
| instMem | input | 3 | Memory-access flag per entry |
| instUops | input | 3x4x16 | Micro-op payloads per entry; a restricted slot uses payload 0 only |
| consumeCnt | output | 2 | Entries to remove from the queue head |
| outUops | output | 6x16 | Packed micro-op lanes |
| outLaneValid | output | 6 | Valid bit per lane |
| seqStart | output | 1 | One-cycle pulse that hands the head to the sequencer |

## Verification
The properties rely on three assumptions about the inputs:
- seqDone is raised only while a handoff is outstanding.
- Every valid entry has a micro-op count of at least 1.
- The window shown in each cycle has already been advanced by the consume count visible in that cycle.

The directed tasks respect all three. Each task drives a fresh window after every clock edge, as if the queue had just popped. Each uses counts of 1 or more, and each pulses seqDone only after a start pulse. The freeze and flush properties compare outputs across one edge. So the bench changes ready and flush only between edges, never at them.

// File: rtl/decode_steer_pkg.sv
package decode_steer_pkg;
  localparam int unsigned NSLOT = 3;
  localparam int unsigned HEADW = 3;

  typedef struct packed {
    logic             load;
    logic             clear;
    logic [NSLOT-1:0] accept;
    logic [HEADW-1:0] headN;
  } dpCtl_t;
endpackage

// File: rtl/decode_steer_ctrl.sv
module decode_steer_ctrl
  import decode_steer_pkg::*;
#(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned GEN_MAX = 4,
  parameter int unsigned CW      = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        downReady,
  input  logic                        seqDone,
  input  logic [NSLOT-1:0]            instValid,
  input  logic [NSLOT-1:0][CNT_W-1:0] instUopCnt,
  input  logic [NSLOT-1:0]            instMem,
  output dpCtl_t                      ctl,
  output logic [CW-1:0]               cntReg,
  output logic                        seqStart,
  output logic                        busy
);
  logic headLong, canDecode, startSeq;
  logic [CW-1:0] nAccept;

  always_comb begin
    headLong  = instValid[0] && (instUopCnt[0] > CNT_W'(GEN_MAX));
    canDecode = !busy && downReady && !flush;
    startSeq  = canDecode && headLong;
    ctl.accept    = '0;
    ctl.accept[0] = canDecode && instValid[0] && !headLong;
    for (int i = 1; i < NSLOT; i++) begin
      ctl.accept[i] = ctl.accept[i-1] && instValid[i] &&
                      (instUopCnt[i] == CNT_W'(1)) && !instMem[i];
    end
    ctl.headN = ctl.accept[0] ? HEADW'(instUopCnt[0]) : '0;
    ctl.load  = downReady;
    ctl.clear = flush;
    nAccept = '0;
    for (int i = 0; i < NSLOT; i++) begin
      nAccept = nAccept + CW'(ctl.accept[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      seqStart <= 1'b0;
      cntReg   <= '0;
    end else begin
      seqStart <= startSeq;
      if (flush)         busy <= 1'b0;
      else if (startSeq) busy <= 1'b1;
      else if (seqDone)  busy <= 1'b0;
      if (flush || !downReady) cntReg <= '0;
      else if (startSeq)       cntReg <= CW'(1);
      else                     cntReg <= nAccept;
    end
  end
endmodule

// File: rtl/decode_steer_dp.sv
module decode_steer_dp
  import decode_steer_pkg::*;
#(
  parameter int unsigned UOP_W   = 16,
  parameter int unsigned GEN_MAX = 4,
  parameter int unsigned LANES   = 6
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  dpCtl_t                                    ctl,
  input  logic [NSLOT-1:0][GEN_MAX-1:0][UOP_W-1:0]  instUops,
  output logic [LANES-1:0][UOP_W-1:0]               outUops,
  output logic [LANES-1:0]                          outLaneValid
);
  localparam int unsigned LW = $clog2(LANES + 1);

  logic [NSLOT-1:0][LW-1:0]     base;
  logic [LANES-1:0]             nxtV;
  logic [LANES-1:0][UOP_W-1:0]  nxtD;
  logic                         unusedBits;

  assign unusedBits = ^instUops;

  always_comb begin
    base[0] = '0;
    base[1] = LW'(ctl.headN);
    for (int i = 2; i < NSLOT; i++) begin
      base[i] = base[i-1] + LW'(ctl.accept[i-1]);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      nxtV[l] = 1'b0;
      nxtD[l] = '0;
      if (l < GEN_MAX) begin
        if (ctl.accept[0] && (LW'(l) < LW'(ctl.headN))) begin
          nxtV[l] = 1'b1;
          nxtD[l] = instUops[0][l % GEN_MAX];
        end
      end
      for (int i = 1; i < NSLOT; i++) begin
        if (ctl.accept[i] && base[i] == LW'(l)) begin
          nxtV[l] = 1'b1;
          nxtD[l] = instUops[i][0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outLaneValid <= '0;
      outUops      <= '0;
    end else if (ctl.clear) begin
      outLaneValid <= '0;
    end else if (ctl.load) begin
      outLaneValid <= nxtV;
      outUops      <= nxtD;
    end
  end
endmodule

// File: rtl/decode_steer.sv
module decode_steer
  import decode_steer_pkg::*;
#(
  parameter int unsigned UOP_W   = 16,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned GEN_MAX = 4,
  parameter int unsigned LANES   = GEN_MAX + NSLOT - 1,
  parameter int unsigned CW      = $clog2(NSLOT + 1)
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      flush,
  input  logic                                      downReady,
  input  logic                                      seqDone,
  input  logic [NSLOT-1:0]                          instValid,
  input  logic [NSLOT-1:0][CNT_W-1:0]               instUopCnt,
  input  logic [NSLOT-1:0]                          instMem,
  input  logic [NSLOT-1:0][GEN_MAX-1:0][UOP_W-1:0]  instUops,
  output logic [CW-1:0]                             consumeCnt,
  output logic [LANES-1:0][UOP_W-1:0]               outUops,
  output logic [LANES-1:0]                          outLaneValid,
  output logic                                      seqStart
);
  dpCtl_t        ctl;
  logic [CW-1:0] cntReg;
  logic          busy;

  decode_steer_ctrl #(.CNT_W(CNT_W), .GEN_MAX(GEN_MAX), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .downReady(downReady),
    .seqDone(seqDone), .instValid(instValid), .instUopCnt(instUopCnt),
    .instMem(instMem), .ctl(ctl), .cntReg(cntReg), .seqStart(seqStart),
    .busy(busy)
  );

  decode_steer_dp #(.UOP_W(UOP_W), .GEN_MAX(GEN_MAX), .LANES(LANES)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .instUops(instUops),
    .outUops(outUops), .outLaneValid(outLaneValid)
  );

  assign consumeCnt = flush ? '0 : cntReg;
endmodule

// File: rtl/decode_steer_chk.sv
module decode_steer_chk #(
  parameter int unsigned UOP_W = 16,
  parameter int unsigned LANES = 6,
  parameter int unsigned CW    = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          flush,
  input logic                          downReady,
  input logic                          busy,
  input logic                          seqStart,
  input logic [CW-1:0]                 consumeCnt,
  input logic [LANES-1:0][UOP_W-1:0]   outUops,
  input logic [LANES-1:0]              outLaneValid
);
  assert_lanes_packed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (outLaneValid & (outLaneValid + 1'b1)) == '0);

  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!downReady && !flush) |=> (consumeCnt == '0) && $stable(outUops) && $stable(outLaneValid));

  assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (outLaneValid == '0) && !seqStart);

  assert_seq_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seqStart && !flush) |-> (consumeCnt == CW'(1)) && (outLaneValid == '0));

  assert_seq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seqStart |=> !seqStart);

  assert_busy_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seqStart) |-> (consumeCnt == '0) && (outLaneValid == '0));
endmodule

bind decode_steer decode_steer_chk #(.UOP_W(UOP_W), .LANES(LANES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .downReady(downReady), .busy(busy),
  .seqStart(seqStart), .consumeCnt(consumeCnt), .outUops(outUops),
  .outLaneValid(outLaneValid)
);

// File: tb/sim_decode_steer.sv
`timescale 1ns/1ps
module sim_decode_steer;
  localparam int UOP_W = 16, CNT_W = 4, GEN_MAX = 4, NS = 3, LANES = 6;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, downReady = 1'b1, seqDone = 1'b0;
  logic [NS-1:0] instValid = '0, instMem = '0;
  logic [NS-1:0][CNT_W-1:0] instUopCnt = '0;
  logic [NS-1:0][GEN_MAX-1:0][UOP_W-1:0] instUops = '0;
  logic [1:0] consumeCnt;
  logic [LANES-1:0][UOP_W-1:0] outUops;
  logic [LANES-1:0] outLaneValid;
  logic seqStart;
  int nTests = 0, nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  decode_steer u0 (.clk(clk), .rst_n(rst_n), .flush(flush), .downReady(downReady),
    .seqDone(seqDone), .instValid(instValid), .instUopCnt(instUopCnt), .instMem(instMem),
    .instUops(instUops), .consumeCnt(consumeCnt), .outUops(outUops),
    .outLaneValid(outLaneValid), .seqStart(seqStart));

  function automatic logic [UOP_W-1:0] uop(int s, int j, int salt);
    return UOP_W'(16'hC000 + salt * 256 + s * 16 + j);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearWin();
    instValid = '0; instMem = '0; instUopCnt = '0; instUops = '0;
  endtask

  task automatic setSlot(int s, bit v, int n, bit m, int salt);
    instValid[s] = v; instUopCnt[s] = CNT_W'(n); instMem[s] = m;
    for (int j = 0; j < GEN_MAX; j++) instUops[s][j] = uop(s, j, salt);
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic t_reset();
    chk("R1 consume", consumeCnt, 0);
    chk("R1 lanes", outLaneValid, 0);
    chk("R1 seqStart", seqStart, 0);
  endtask

  task automatic t_head_multi();
    clearWin(); setSlot(0,1,3,0,1); setSlot(1,1,1,0,1); setSlot(2,1,1,1,1);
    step();
    chk("R2/R5 consume", consumeCnt, 2);
    chk("R2 lanes", outLaneValid, 6'b001111);
    chk("R2 lane2", outUops[2], uop(0,2,1));
    chk("R3 lane3", outUops[3], uop(1,0,1));
  endtask

  task automatic t_all_simple();
    clearWin(); setSlot(0,1,1,0,2); setSlot(1,1,1,0,2); setSlot(2,1,1,0,2);
    step();
    chk("R10 consume", consumeCnt, 3);
    chk("R10 lanes", outLaneValid, 6'b000111);
    chk("R3 lane1", outUops[1], uop(1,0,2));
    chk("R3 lane2", outUops[2], uop(2,0,2));
  endtask

  task automatic t_block();
    clearWin(); setSlot(0,1,1,0,3); setSlot(1,1,2,0,3); setSlot(2,1,1,0,3);
    step();
    chk("R4 consume", consumeCnt, 1);
    chk("R4 lanes", outLaneValid, 6'b000001);
  endtask

  task automatic t_head_mem4();
    clearWin(); setSlot(0,1,4,1,4); setSlot(1,1,1,0,4); setSlot(2,1,1,0,4);
    step();
    chk("R2 mem head consume", consumeCnt, 3);
    chk("R10 lanes full", outLaneValid, 6'b111111);
    chk("R3 lane4", outUops[4], uop(1,0,4));
    chk("R3 lane5", outUops[5], uop(2,0,4));
  endtask

  task automatic t_invalid();
    clearWin(); setSlot(0,0,1,0,5); setSlot(1,1,1,0,5); setSlot(2,1,1,0,5);
    step();
    chk("R11 head invalid consume", consumeCnt, 0);
    chk("R11 head invalid lanes", outLaneValid, 0);
    clearWin(); setSlot(0,1,1,0,5); setSlot(1,0,1,0,5); setSlot(2,1,1,0,5);
    step();
    chk("R11 gap consume", consumeCnt, 1);
    chk("R11 gap lanes", outLaneValid, 6'b000001);
  endtask

  task automatic t_seq();
    clearWin(); setSlot(0,1,7,0,6); setSlot(1,1,1,0,6);
    step();
    chk("R6 seqStart", seqStart, 1);
    chk("R6 consume", consumeCnt, 1);
    chk("R6 lanes", outLaneValid, 0);
    clearWin(); setSlot(0,1,1,0,7); setSlot(1,1,1,0,7);
    step();
    chk("R6 pulse", seqStart, 0);
    chk("R7 busy consume", consumeCnt, 0);
    step();
    chk("R7 busy lanes", outLaneValid, 0);
    seqDone = 1'b1;
    step();
    seqDone = 1'b0;
    chk("R7 done cycle consume", consumeCnt, 0);
    step();
    chk("R7 resume consume", consumeCnt, 2);
    chk("R7 resume lanes", outLaneValid, 6'b000011);
  endtask

  task automatic t_freeze();
    clearWin(); setSlot(0,1,1,0,8); setSlot(1,1,1,0,8); setSlot(2,1,1,0,8);
    step();
    chk("R8 pre consume", consumeCnt, 3);
    downReady = 1'b0;
    clearWin(); setSlot(0,1,2,0,9);
    step();
    chk("R8 frozen consume", consumeCnt, 0);
    chk("R8 frozen lanes", outLaneValid, 6'b000111);
    chk("R8 frozen data", outUops[1], uop(1,0,8));
    downReady = 1'b1;
    step();
    chk("R8 thaw consume", consumeCnt, 1);
    chk("R8 thaw data", outUops[1], uop(0,1,9));
  endtask

  task automatic t_flush();
    clearWin(); setSlot(0,1,6,0,10);
    step();
    chk("R9 pre seqStart", seqStart, 1);
    flush = 1'b1; #1;
    chk("R9 same-cycle consume", consumeCnt, 0);
    step();
    flush = 1'b0;
    chk("R9 after consume", consumeCnt, 0);
    clearWin(); setSlot(0,1,1,0,11);
    step();
    chk("R9 resume consume", consumeCnt, 1);
    chk("R9 resume lanes", outLaneValid, 6'b000001);
  endtask

  initial begin
    #(20.0 * 150000);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 in reset", outLaneValid, 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();
    t_reset();
    t_head_multi();
    t_all_simple();
    t_block();
    t_head_mem4();
    t_invalid();
    t_seq();
    t_freeze();
    t_flush();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule